// File: doc/BRIEF.md
# Selectable-Source Up/Down Timer Counter

This block is the counting stage of a microcontroller timer. It picks one of eight candidate count clocks and advances a cyclic count value once per rising edge of that clock. Six of the candidates are prescaler taps. The other two are port-pin inputs, and each pin has its own polarity inversion and an optional divide-by-two path. Software chooses the direction, an active length of 4, 6, 8 or 10 bits, and whether counting waits for a clean clock period before the first step. A one-cycle interrupt pulse marks every roll-over.

Everything runs on the system clock. The chosen source is resynchronised and turned into rising and falling edge pulses, so no register is clocked by a slow or external signal. A load strobe writes the start value. Clearing the start bit freezes the value in place.

Top module: `tmr_cnt_top`

## Requirements
- R1: `src_sel` values 0 to 5 pick `tap_in[0]` to `tap_in[5]`, value 6 picks `pin_in[0]` and value 7 picks `pin_in[1]`. Edges on sources that are not selected never move the count.
- R2: When `pin_inv[i]` is 1, pin i is inverted before use, so a falling edge on the pin becomes a rising edge of the count clock.
- R3: Each counted rising edge adds 1 when `count_up` is 1 and subtracts 1 when `count_up` is 0 (0 is the down direction).
- R4: The count wraps cyclically within the active length in both directions. Any step clears every bit above the active length.
- R5: The roll-over pulse fires when a step makes the active bits all ones (counting up) or all zeros (counting down). Bits above the active length play no part in this test.
- R6: `irq_roll` is high for exactly one system-clock cycle, in the cycle when the count shows the roll-over value.
- R7: `len_sel` encodes the active length as 0 = 4 bits, 1 = 6 bits, 2 = 8 bits and 3 = 10 bits.
- R8: When `pin_halve[i]` is 1, pin i feeds a divide-by-two stage. The stage is cleared while `start` is 0, so the count steps on the 1st, 3rd, 5th and later odd falling edges of the polarity-adjusted pin after start.
- R9: With `ev_mode` = 0, a rising edge counts only after a falling edge of the selected clock has been seen while `start` is 1.
- R10: With `ev_mode` = 1, every rising edge of the selected clock while `start` is 1 counts, including the first one.
- R11: While `start` is 0 the count holds its value and the seen-falling-edge flag is cleared, so R9 applies again after a restart.
- R12: A `load` pulse sets the count to `load_val`, and a load takes priority over a step in the same cycle. Reset clears the count and `irq_roll` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_in | input | 6 | Prescaler clock taps |
| pin_in | input | 2 | Port-pin clock inputs (index 0 and index 1) |
| pin_inv | input | 2 | Per-pin polarity inversion |
| pin_halve | input | 2 | Per-pin divide-by-two enable |
| src_sel | input | 3 | Count source select |
| count_up | input | 1 | Direction: 1 up, 0 down |
| len_sel | input | 2 | Active length code |
| ev_mode | input | 1 | Event mode: skip the falling-edge start condition |
| start | input | 1 | Run enable |
| load | input | 1 | Load strobe |
| load_val | input | 10 | Value written by load |
| count | output | 10 | Current count value |
| irq_roll | output | 1 | One-cycle roll-over pulse |

## Verification
The hardest state to reach from the ports is the start guard: a rising edge that arrives before any falling edge since start must be ignored, and a restart must bring that guard back. The stimulus leaves the selected source low when start rises, so the first full source period contributes only its falling edge. It then clears start in the middle of a run and checks that the next period is swallowed again. The divided pin path is the other difficult case. Whether a step happens depends on the parity of the pin's falling edges since start, so the pin is driven one period at a time and the count is read after each period.

// File: rtl/tmr_cnt_pkg.sv
package tmr_cnt_pkg;
  localparam int CNT_W = 10;

  typedef enum logic [1:0] {
    LEN_4  = 2'd0,
    LEN_6  = 2'd1,
    LEN_8  = 2'd2,
    LEN_10 = 2'd3
  } len_e;

  // active-bit mask for a length code
  function automatic logic [CNT_W-1:0] len_mask(input logic [1:0] code);
    logic [CNT_W-1:0] m;
    case (len_e'(code))
      LEN_4:   m = CNT_W'(10'h00F);
      LEN_6:   m = CNT_W'(10'h03F);
      LEN_8:   m = CNT_W'(10'h0FF);
      default: m = CNT_W'(10'h3FF);
    endcase
    return m;
  endfunction

  // value after one step, wrapped inside the active length
  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] v,
                                                 input logic up,
                                                 input logic [1:0] code);
    logic [CNT_W-1:0] raw;
    raw = up ? (v + CNT_W'(1)) : (v - CNT_W'(1));
    return raw & len_mask(code);
  endfunction

  // roll-over condition on the active bits only
  function automatic logic roll_hit(input logic [CNT_W-1:0] v,
                                    input logic up,
                                    input logic [1:0] code);
    logic [CNT_W-1:0] m;
    m = len_mask(code);
    return up ? ((v & m) == m) : ((v & m) == '0);
  endfunction
endpackage

// File: rtl/tmr_cnt_src.sv
module tmr_cnt_src #(
  parameter int NTAP = 6,
  parameter int NPIN = 2,
  localparam int SW  = $clog2(NTAP + NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NTAP-1:0] tap_in,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_inv,
  input  logic [NPIN-1:0] pin_halve,
  input  logic [SW-1:0]   sel,
  output logic            src_clk
);
  logic [NPIN-1:0] pin_path;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [1:0] sync_q;
    logic       prev_q;
    logic       div_q;
    logic       pol;
    logic       pin_fall;

    assign pol      = sync_q[1] ^ pin_inv[g];
    assign pin_fall = prev_q & ~pol;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
        div_q  <= 1'b0;
      end else begin
        sync_q <= {sync_q[0], pin_in[g]};
        prev_q <= pol;
        if (!start)        div_q <= 1'b0;
        else if (pin_fall) div_q <= ~div_q;
      end
    end

    assign pin_path[g] = pin_halve[g] ? div_q : pol;
  end

  always_comb begin
    src_clk = 1'b0;
    for (int i = 0; i < NTAP; i++)
      if (sel == SW'(i)) src_clk = tap_in[i];
    for (int i = 0; i < NPIN; i++)
      if (sel == SW'(NTAP + i)) src_clk = pin_path[i];
  end
endmodule

// File: rtl/tmr_cnt_edge.sv
module tmr_cnt_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
  import tmr_cnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ev_mode,
  input  logic             count_up,
  input  logic [1:0]       len_sel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rise,
  input  logic             fall,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             armed,
  output logic             step
);
  logic [CNT_W-1:0] nxt;

  assign step = start && !load && rise && (ev_mode || armed);
  assign nxt  = step_val(count, count_up, len_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!start)    armed <= 1'b0;
      else if (fall) armed <= 1'b1;
      if (load) begin
        count <= load_val;
      end else if (step) begin
        count <= nxt;
        irq   <= roll_hit(nxt, count_up, len_sel);
      end
    end
  end
endmodule

// File: rtl/tmr_cnt_top.sv
module tmr_cnt_top
  import tmr_cnt_pkg::*;
#(
  parameter int NTAP = 6,
  parameter int NPIN = 2,
  localparam int SW  = $clog2(NTAP + NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAP-1:0]  tap_in,
  input  logic [NPIN-1:0]  pin_in,
  input  logic [NPIN-1:0]  pin_inv,
  input  logic [NPIN-1:0]  pin_halve,
  input  logic [SW-1:0]    src_sel,
  input  logic             count_up,
  input  logic [1:0]       len_sel,
  input  logic             ev_mode,
  input  logic             start,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             irq_roll
);
  logic src_clk_w;
  logic rise_w;
  logic fall_w;
  logic armed_w;
  logic step_w;

  tmr_cnt_src #(.NTAP(NTAP), .NPIN(NPIN)) u_src (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tap_in(tap_in), .pin_in(pin_in), .pin_inv(pin_inv),
    .pin_halve(pin_halve), .sel(src_sel), .src_clk(src_clk_w)
  );

  tmr_cnt_edge #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .d(src_clk_w), .rise(rise_w), .fall(fall_w)
  );

  tmr_cnt_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .ev_mode(ev_mode),
    .count_up(count_up), .len_sel(len_sel), .load(load),
    .load_val(load_val), .rise(rise_w), .fall(fall_w),
    .count(count), .irq(irq_roll), .armed(armed_w), .step(step_w)
  );
endmodule

// File: rtl/tmr_cnt_chk.sv
module tmr_cnt_chk
  import tmr_cnt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ev_mode,
  input logic             count_up,
  input logic [1:0]       len_sel,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count,
  input logic             irq_roll,
  input logic             rise_w,
  input logic             fall_w,
  input logic             armed_w,
  input logic             step_w
);
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_w, fall_w}));  // R9

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && count_up) |=>
      (((count - $past(count)) & len_mask($past(len_sel))) == CNT_W'(1)));  // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !count_up) |=>
      ((($past(count) - count) & len_mask($past(len_sel))) == CNT_W'(1)));  // R3

  AST_HIGH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> ((count & ~len_mask($past(len_sel))) == '0));  // R4

  AST_IRQ_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_roll |-> roll_hit(count, $past(count_up), $past(len_sel)));  // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_roll |=> !irq_roll);  // R6

  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_mode && !armed_w && !load) |=> $stable(count));  // R9

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !load) |=> $stable(count));  // R11

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));  // R12
endmodule

bind tmr_cnt_top tmr_cnt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ev_mode(ev_mode),
  .count_up(count_up), .len_sel(len_sel), .load(load), .load_val(load_val),
  .count(count), .irq_roll(irq_roll), .rise_w(rise_w), .fall_w(fall_w),
  .armed_w(armed_w), .step_w(step_w)
);

// File: tb/tmr_cnt_top_tb.sv
module tmr_cnt_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] tap_in = '0;
  logic [1:0] pin_in = '0;
  logic [1:0] pin_inv = '0;
  logic [1:0] pin_halve = '0;
  logic [2:0] src_sel = '0;
  logic       count_up = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       ev_mode = 1'b0;
  logic       start = 1'b0;
  logic       load = 1'b0;
  logic [9:0] load_val = '0;
  logic [9:0] count;
  logic       irq_roll;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  tmr_cnt_top u_dut (
    .clk(clk), .rst_n(rst_n), .tap_in(tap_in), .pin_in(pin_in),
    .pin_inv(pin_inv), .pin_halve(pin_halve), .src_sel(src_sel),
    .count_up(count_up), .len_sel(len_sel), .ev_mode(ev_mode),
    .start(start), .load(load), .load_val(load_val),
    .count(count), .irq_roll(irq_roll)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq_roll) irq_seen++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flip(input int which);
    if (which < 6) tap_in[which] = ~tap_in[which];
    else pin_in[which-6] = ~pin_in[which-6];
  endtask

  // n full periods of a source, starting from its idle level
  task automatic src_cycles(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      flip(which); wait_cyc(8);
      flip(which); wait_cyc(8);
    end
    wait_cyc(8);
  endtask

  task automatic stop_run();
    start = 1'b0;
    wait_cyc(2);
  endtask

  task automatic go(input logic [9:0] v);
    wait_cyc(6);
    load_val = v; load = 1'b1;
    wait_cyc(1);
    load = 1'b0;
    irq_seen = 0;
    start = 1'b1;
    wait_cyc(6);
  endtask

  task automatic t_reset();
    chk("R12 reset count", count, 10'h000);
    chk("R12 reset irq", {9'd0, irq_roll}, 10'h000);
  endtask

  task automatic t_guard();
    stop_run(); src_sel = 3'd0; count_up = 1'b0; len_sel = 2'd3; ev_mode = 1'b0;
    go(10'h005);
    src_cycles(0, 1);
    chk("R9 first rise ignored", count, 10'h005);
    src_cycles(0, 1);
    chk("R9 step after fall", count, 10'h004);
  endtask

  task automatic t_event_select();
    stop_run(); src_sel = 3'd3; count_up = 1'b1; len_sel = 2'd3; ev_mode = 1'b1;
    go(10'h010);
    src_cycles(3, 3);
    chk("R10 every rise counts", count, 10'h013);
    src_cycles(2, 3);
    chk("R1 unselected tap ignored", count, 10'h013);
  endtask

  task automatic t_up4();
    stop_run(); src_sel = 3'd1; count_up = 1'b1; len_sel = 2'd0; ev_mode = 1'b1;
    go(10'h00D);
    src_cycles(1, 3);
    chk("R4 4-bit wrap up", count, 10'h000);
    chk("R6 one-cycle pulse count", 10'(irq_seen), 10'd1);
  endtask

  task automatic t_len6();
    stop_run(); src_sel = 3'd1; count_up = 1'b1; len_sel = 2'd1; ev_mode = 1'b1;
    go(10'h03C);
    src_cycles(1, 3);
    chk("R7 6-bit top", count, 10'h03F);
    chk("R5 irq at 3F", 10'(irq_seen), 10'd1);
    src_cycles(1, 1);
    chk("R4 6-bit wrap", count, 10'h000);
    chk("R5 no irq on wrap to 0 up", 10'(irq_seen), 10'd1);
  endtask

  task automatic t_mask();
    stop_run(); src_sel = 3'd4; count_up = 1'b0; len_sel = 2'd0; ev_mode = 1'b1;
    go(10'h3F3);
    src_cycles(4, 1);
    chk("R4 upper bits cleared", count, 10'h002);
    chk("R5 no early irq", 10'(irq_seen), 10'd0);
    src_cycles(4, 2);
    chk("R5 down to zero", count, 10'h000);
    chk("R5 irq on low bits zero", 10'(irq_seen), 10'd1);
  endtask

  task automatic t_len10_len8();
    stop_run(); src_sel = 3'd5; count_up = 1'b0; len_sel = 2'd3; ev_mode = 1'b1;
    go(10'h001);
    src_cycles(5, 2);
    chk("R4 10-bit wrap down", count, 10'h3FF);
    chk("R5 irq at zero", 10'(irq_seen), 10'd1);
    stop_run(); count_up = 1'b1; len_sel = 2'd2;
    go(10'h0FE);
    src_cycles(5, 1);
    chk("R7 8-bit top", count, 10'h0FF);
    chk("R5 irq at FF", 10'(irq_seen), 10'd1);
  endtask

  task automatic t_pin_inv();
    stop_run(); pin_inv = 2'b01; pin_halve = 2'b00; pin_in[0] = 1'b1;
    src_sel = 3'd6; count_up = 1'b1; len_sel = 2'd3; ev_mode = 1'b0;
    go(10'h020);
    src_cycles(6, 4);
    chk("R2 inverted pin steps", count, 10'h023);
  endtask

  task automatic t_halve();
    stop_run(); pin_inv = 2'b00; pin_halve = 2'b10; pin_in[1] = 1'b0;
    src_sel = 3'd7; count_up = 1'b1; len_sel = 2'd3; ev_mode = 1'b1;
    go(10'h000);
    src_cycles(7, 1);
    chk("R8 first pin fall", count, 10'h001);
    src_cycles(7, 1);
    chk("R8 second pin fall", count, 10'h001);
    src_cycles(7, 1);
    chk("R8 third pin fall", count, 10'h002);
  endtask

  task automatic t_stop();
    stop_run(); pin_halve = 2'b00; src_sel = 3'd0; count_up = 1'b0;
    len_sel = 2'd3; ev_mode = 1'b0;
    go(10'h100);
    src_cycles(0, 2);
    chk("R3 down step", count, 10'h0FF);
    start = 1'b0;
    src_cycles(0, 3);
    chk("R11 frozen while stopped", count, 10'h0FF);
    start = 1'b1; wait_cyc(4);
    src_cycles(0, 1);
    chk("R11 guard rearmed", count, 10'h0FF);
    src_cycles(0, 1);
    chk("R11 resumes", count, 10'h0FE);
  endtask

  task automatic t_load();
    stop_run(); src_sel = 3'd2; count_up = 1'b1; len_sel = 2'd3; ev_mode = 1'b1;
    go(10'h050);
    load_val = 10'h123; load = 1'b1;
    src_cycles(2, 2);
    chk("R12 load beats step", count, 10'h123);
    load = 1'b0; wait_cyc(2);
    src_cycles(2, 1);
    chk("R3 up after load", count, 10'h124);
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_guard();
    t_event_select();
    t_up4();
    t_len6();
    t_mask();
    t_len10_len8();
    t_pin_inv();
    t_halve();
    t_stop();
    t_load();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule